// File: doc/BRIEF.md
# Core Boot and Status Controller

This block is a small register window that brings an attached processor core out of reset in a safe order and then watches it. Software reaches it through a single-beat register port. Through that port it can hold the core in reset, open or close the core's clock gate, and set the address the core fetches from first. It can also read back whether the core has halted or faulted. The clock gate is modelled as an enable, `coreClkEn`, that a real gating cell elsewhere would use.

The enable combines three inputs. The first is the software gate bit. The second is the core's wait-for-interrupt flag, which closes the gate while the core sleeps. The third is an active-low interrupt line. It passes through a synchronizer and is latched as a wake request, so the core clocks again until it leaves its sleep state. The block also makes sure the core sees at least one clocked cycle in reset before reset is released, even if software clears reset too early.

Top module: `core_boot_ctrl`

## Requirements
- R1: After `rstN` is low at a clock edge, `coreReset` is 1, `coreClkEn` is 0 and `coreStartPc` is 0. The control word at window offset 0x0 reads 3: bit 0 is core reset and bit 1 is gate closed.
- R2: Writing 1 to the control word opens the gate (`coreClkEn` rises in the next cycle) and keeps `coreReset` high. A later write of 0 lowers `coreReset` in the cycle after that write.
- R3: If reset is cleared before the core has had one enabled cycle in reset, `coreReset` stays high for exactly one more enabled cycle. The same happens when software writes 0 directly from the reset state, and `coreClkEn` is already high in that extra cycle.
- R4: The start-address register at offset 0x4 resets to 0 and reads back what was written. It drives `coreStartPc` from the cycle after the write.
- R5: The status word at offset 0x8 reads bit 0 as halted and bit 1 as fault. Both come from inputs sampled one clock before the read is taken.
- R6: Writes to the status offset change nothing: the start address, the control word and the status readback all stay as they were.
- R7: While `coreWfi` is high and no wake request is latched, `coreClkEn` is 0 even with the gate bit open.
- R8: A low `irqN` during wait-for-interrupt raises `coreClkEn` on the third clock edge after it is sampled. The wake stays latched after `irqN` returns high, for as long as `coreWfi` stays high.
- R9: An interrupt pulse that arrives and ends while `coreWfi` is low leaves nothing latched. A later rise of `coreWfi` gates the clock.
- R10: Read data appears on `regRData` one clock after the read request. Offsets outside the three registers read 0.
- R11: Writing 2 (gate closed, reset clear) to a running core drops `coreClkEn` and leaves `coreReset` low. Writing 0 afterwards reopens the gate with no new reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and core clock |
| rstN | input | 1 | Synchronous active-low reset |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 for write, 0 for read |
| regAddr | input | ADDR_W (20) | Absolute access address |
| regWData | input | DATA_W (32) | Write data |
| regRData | output | DATA_W (32) | Read data, one cycle after the request |
| coreHalted | input | 1 | Core reports it has halted |
| coreFault | input | 1 | Core reports a fault |
| coreWfi | input | 1 | Core is waiting for an interrupt |
| irqN | input | 1 | Active-low asynchronous wake interrupt |
| coreReset | output | 1 | Active-high reset to the core |
| coreClkEn | output | 1 | Effective core clock enable |
| coreStartPc | output | PC_W (32) | First fetch address for the core |

## Verification
Register writes reach `coreReset`, `coreClkEn` and `coreStartPc` in the cycle after the request edge. The early-release case of R3 adds one more edge before reset drops. Read data is due one edge after a read is sampled, and the status bits it returns were sampled one edge before that read. A wake interrupt reaches the enable on the third edge: two synchronizer stages and then the latch. The bench drives every input on a falling edge and checks outputs on the falling edge that follows the edge where each result is due. Reads go through an expectation queue that the monitor pops one edge after each sampled read.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_PC   = 2'd2,
    SEL_STAT = 2'd3
  } rdSel_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic   wrCtl;
    logic   wrPc;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;

  localparam int CTL_W  = 2;
  localparam int STAT_W = 2;

endpackage

// File: rtl/boot_wake.sv
module boot_wake #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic irqN,
  input  logic coreWfi,
  output logic irqPend
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   irqReq;
  logic                   pendQ;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= irqN;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign irqReq = ~syncQ[SYNC_STAGES-1];

  // wake request held while the core sleeps, dropped once it leaves
  always_ff @(posedge clk) begin
    if (!rstN)        pendQ <= 1'b0;
    else if (coreWfi) pendQ <= pendQ | irqReq;
    else              pendQ <= 1'b0;
  end

  assign irqPend = pendQ;

  assert_pend_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    !coreWfi |=> !irqPend);

  assert_pend_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend && coreWfi) |=> irqPend);

endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h30000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CTL_W-1:0]  wrBits,
  input  logic              coreWfi,
  input  logic              irqPend,
  output regStrobe_t        strb,
  output logic [CTL_W-1:0]  ctlBits,
  output logic              coreReset,
  output logic              coreClkEn
);

  localparam logic [ADDR_W-1:0] ADDR_CTL  = BASE_ADDR;
  localparam logic [ADDR_W-1:0] ADDR_PC   = BASE_ADDR + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] ADDR_STAT = BASE_ADDR + ADDR_W'(8);

  logic [CTL_W-1:0] ctlQ;
  logic             primedQ;
  logic             swOpen;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    if (regValid) begin
      if (regWrite) begin
        strb.wrCtl = (regAddr == ADDR_CTL);
        strb.wrPc  = (regAddr == ADDR_PC);
      end else begin
        strb.rdEn = 1'b1;
        if      (regAddr == ADDR_CTL)  strb.rdSel = SEL_CTL;
        else if (regAddr == ADDR_PC)   strb.rdSel = SEL_PC;
        else if (regAddr == ADDR_STAT) strb.rdSel = SEL_STAT;
      end
    end
  end

  // bit 0: hold core in reset, bit 1: gate closed
  always_ff @(posedge clk) begin
    if (!rstN)           ctlQ <= 2'b11;
    else if (strb.wrCtl) ctlQ <= wrBits;
  end

  // set once the core has been clocked with reset applied
  always_ff @(posedge clk) begin
    if (!rstN)                         primedQ <= 1'b0;
    else if (strb.wrCtl && wrBits[0])  primedQ <= 1'b0;
    else if (coreReset && coreClkEn)   primedQ <= 1'b1;
  end

  assign swOpen    = ~ctlQ[1];
  assign coreClkEn = swOpen & (~coreWfi | irqPend);
  assign coreReset = ctlQ[0] | ~primedQ;
  assign ctlBits   = ctlQ;

  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrCtl && rstN) |-> ctlBits == $past(wrBits));

  assert_release_after_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreReset) |-> $past(swOpen));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtl, strb.wrPc, strb.rdEn}));

endmodule

// File: rtl/boot_dpath.sv
module boot_dpath
  import boot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] regWData,
  input  logic [CTL_W-1:0]  ctlBits,
  input  logic              coreHalted,
  input  logic              coreFault,
  output logic [PC_W-1:0]   coreStartPc,
  output logic [DATA_W-1:0] regRData
);

  logic [PC_W-1:0]   startPcQ;
  logic [STAT_W-1:0] statusQ;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] rDataQ;

  always_ff @(posedge clk) begin
    if (!rstN)          startPcQ <= '0;
    else if (strb.wrPc) startPcQ <= regWData[PC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= {coreFault, coreHalted};
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTL:  rdMux = DATA_W'(ctlBits);
      SEL_PC:   rdMux = DATA_W'(startPcQ);
      SEL_STAT: rdMux = DATA_W'(statusQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rDataQ <= '0;
    else if (strb.rdEn) rDataQ <= rdMux;
  end

  assign coreStartPc = startPcQ;
  assign regRData    = rDataQ;

  assert_pc_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.wrPc && rstN) |-> coreStartPc == $past(regWData[PC_W-1:0]));

  assert_status_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.rdEn && strb.rdSel == SEL_STAT && rstN)
      |-> regRData == DATA_W'($past(statusQ)));

endmodule

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl
  import boot_pkg::*;
#(
  parameter int                ADDR_W      = 20,
  parameter int                DATA_W      = 32,
  parameter int                PC_W        = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 20'h30000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWData,
  output logic [DATA_W-1:0] regRData,
  input  logic              coreHalted,
  input  logic              coreFault,
  input  logic              coreWfi,
  input  logic              irqN,
  output logic              coreReset,
  output logic              coreClkEn,
  output logic [PC_W-1:0]   coreStartPc
);

  regStrobe_t       strb;
  logic [CTL_W-1:0] ctlBits;
  logic             irqPend;

  boot_wake #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk     (clk),
    .rstN    (rstN),
    .irqN    (irqN),
    .coreWfi (coreWfi),
    .irqPend (irqPend)
  );

  boot_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regValid  (regValid),
    .regWrite  (regWrite),
    .regAddr   (regAddr),
    .wrBits    (regWData[CTL_W-1:0]),
    .coreWfi   (coreWfi),
    .irqPend   (irqPend),
    .strb      (strb),
    .ctlBits   (ctlBits),
    .coreReset (coreReset),
    .coreClkEn (coreClkEn)
  );

  boot_dpath #(.DATA_W(DATA_W), .PC_W(PC_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .regWData    (regWData),
    .ctlBits     (ctlBits),
    .coreHalted  (coreHalted),
    .coreFault   (coreFault),
    .coreStartPc (coreStartPc),
    .regRData    (regRData)
  );

endmodule

// File: tb/core_boot_ctrl_bench.sv
`timescale 1ns/1ps
module core_boot_ctrl_bench;

  localparam logic [19:0] A_CTL  = 20'h30000;
  localparam logic [19:0] A_PC   = 20'h30004;
  localparam logic [19:0] A_STAT = 20'h30008;
  localparam logic [19:0] A_NONE = 20'h3000C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [19:0] regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic        coreHalted = 1'b0;
  logic        coreFault = 1'b0;
  logic        coreWfi = 1'b0;
  logic        irqN = 1'b1;
  logic        coreReset;
  logic        coreClkEn;
  logic [31:0] coreStartPc;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic rdSeen = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  core_boot_ctrl u_core_boot_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWData(regWData), .regRData(regRData),
    .coreHalted(coreHalted), .coreFault(coreFault), .coreWfi(coreWfi),
    .irqN(irqN), .coreReset(coreReset), .coreClkEn(coreClkEn),
    .coreStartPc(coreStartPc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  // driver: issue a read and queue its expected data
  task automatic busRead(input logic [19:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    regValid = 1'b0;
  endtask

  always @(posedge clk) rdSeen <= rstN && regValid && !regWrite;

  // monitor: read data is due one edge after the request
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        total++; fails++;
        $display("FAIL R10: unexpected read data %0h expected none", regRData);
      end else begin
        chk(tagQ.pop_front(), regRData, expQ.pop_front());
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset high", 32'(coreReset), 32'd1);
    chk("R1 clken low", 32'(coreClkEn), 32'd0);
    chk("R1 start pc zero", coreStartPc, 32'd0);
    busRead(A_CTL, 32'd3, "R1 ctrl reads 3");
    busRead(A_PC, 32'd0, "R4 pc default");
    busRead(A_NONE, 32'd0, "R10 unmapped reads 0");

    busWrite(A_PC, 32'h0000_0100);
    chk("R4 pc output", coreStartPc, 32'h100);
    busRead(A_PC, 32'h100, "R4 pc readback");

    busWrite(A_STAT, 32'hFFFF_FFFF);
    busRead(A_STAT, 32'd0, "R6 status unchanged");
    busRead(A_PC, 32'h100, "R6 pc unchanged");
    busRead(A_CTL, 32'd3, "R6 ctrl unchanged");

    // early release straight from reset state
    busWrite(A_CTL, 32'd0);
    chk("R3 clken up", 32'(coreClkEn), 32'd1);
    chk("R3 reset held", 32'(coreReset), 32'd1);
    @(negedge clk);
    chk("R3 reset released", 32'(coreReset), 32'd0);

    // ordered sequence
    busWrite(A_CTL, 32'd3);
    chk("R2 reset reasserted", 32'(coreReset), 32'd1);
    chk("R2 gate closed", 32'(coreClkEn), 32'd0);
    busWrite(A_CTL, 32'd1);
    chk("R2 gate open", 32'(coreClkEn), 32'd1);
    chk("R2 reset kept", 32'(coreReset), 32'd1);
    repeat (2) @(negedge clk);
    chk("R2 reset still kept", 32'(coreReset), 32'd1);
    busWrite(A_CTL, 32'd0);
    chk("R2 reset released", 32'(coreReset), 32'd0);
    busRead(A_CTL, 32'd0, "R2 ctrl readback");

    // status sampling
    @(negedge clk); coreHalted = 1'b1;
    busRead(A_STAT, 32'd1, "R5 halted bit");
    @(negedge clk); coreHalted = 1'b0; coreFault = 1'b1;
    busRead(A_STAT, 32'd2, "R5 fault bit");
    @(negedge clk); coreFault = 1'b0;

    // software gating while running
    busWrite(A_CTL, 32'd2);
    chk("R11 gate closed", 32'(coreClkEn), 32'd0);
    chk("R11 no reset", 32'(coreReset), 32'd0);
    repeat (2) @(negedge clk);
    chk("R11 still no reset", 32'(coreReset), 32'd0);
    busWrite(A_CTL, 32'd0);
    chk("R11 gate reopened", 32'(coreClkEn), 32'd1);
    chk("R11 reset stays low", 32'(coreReset), 32'd0);

    // wait-for-interrupt gating and wake
    @(negedge clk); coreWfi = 1'b1;
    @(negedge clk);
    chk("R7 wfi gates", 32'(coreClkEn), 32'd0);
    irqN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 not yet awake", 32'(coreClkEn), 32'd0);
    @(negedge clk);
    chk("R8 awake third edge", 32'(coreClkEn), 32'd1);
    irqN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 wake latched", 32'(coreClkEn), 32'd1);
    coreWfi = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 running after wfi", 32'(coreClkEn), 32'd1);

    // interrupt pulse outside wfi is not kept
    irqN = 1'b0;
    repeat (2) @(negedge clk);
    irqN = 1'b1;
    repeat (4) @(negedge clk);
    coreWfi = 1'b1;
    @(negedge clk);
    chk("R9 no stale wake", 32'(coreClkEn), 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 still gated", 32'(coreClkEn), 32'd0);
    coreWfi = 1'b0;

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; fails++;
      $display("FAIL R10: actual %0d reads outstanding expected 0", expQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule